// File: doc/BRIEF.md
# Stochastic Bitstream Arithmetic Unit

This unit performs one arithmetic operation on unipolar stochastic bitstreams, where a value is the fraction of 1s in a stream. It takes one bit of each operand per accepted cycle, marked by a valid strobe, and returns one result bit for each accepted bit, one clock later. An operation code is sampled while reset is held, and that operation stays fixed until the next reset.

Each operator is built from per-bit primitives: a delay element that outputs the previous accepted bit of its source, a toggle element whose state flips one accepted bit after a 1 on its input, and gate or multiplexer logic. Multiplication is an AND with a delay element on the y operand. The delay acts as an isolator that removes correlation between x and y. Scaled addition multiplexes x and y under the state of a toggle element driven by the auxiliary input. Absolute difference is an XOR of two positively correlated streams. Halving gates x with a toggle element that x itself drives. Both elements advance only on accepted bits, so gaps in the valid strobe do not disturb the arithmetic.

Top module: `sc_stream_alu`

## Requirements
- R1: While rst_n is low, z_bit and z_vld are 0, and the delay and toggle states clear to 0. The first accepted bit after reset therefore sees a delayed bit of 0 and a toggle state of 0.
- R2: z_vld is 1 exactly in the cycle after a cycle where in_vld was 1. In every cycle where z_vld is 0, z_bit is 0.
- R3: op_sel is sampled on clock edges while rst_n is low. Changes of op_sel after reset has been released have no effect on the result stream.
- R4: With op code 2'b00 (multiply), the result for accepted bit n is x[n] AND y[n-1], where y[n-1] is the y bit of the previous accepted bit, or 0 for the first accepted bit after reset.
- R5: With op code 2'b01 (scaled add), the result for bit n is x[n] when the toggle state t[n] is 1 and y[n] when it is 0. The update is t[n] = t[n-1] XOR aux[n-1].
- R6: In scaled add mode with aux held at 1, the select alternates on every accepted bit, starting with y.
- R7: With op code 2'b10 (absolute difference), the result for bit n is x[n] XOR y[n].
- R8: With op code 2'b11 (halve), the result for bit n is x[n] AND t[n], with t[n] = t[n-1] XOR x[n-1]. Over a stream holding k ones of x, the output therefore holds floor(k/2) ones.
- R9: A cycle with in_vld at 0 leaves the delay and toggle states unchanged, so the next accepted bit continues the sequence as if the gap were absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asynchronous for state, and op_sel is sampled while it is low |
| in_vld | input | 1 | The x, y and aux bits in this cycle are accepted |
| x_bit | input | 1 | Operand x stream bit |
| y_bit | input | 1 | Operand y stream bit |
| aux_bit | input | 1 | Toggle drive bit for scaled add mode |
| op_sel | input | 2 | Operation: 00 multiply, 01 scaled add, 10 absolute difference, 11 halve |
| z_bit | output | 1 | Result stream bit |
| z_vld | output | 1 | z_bit holds a result; one cycle after in_vld |

## Verification
Two things can land on the same accepted bit: a toggle event and the output that uses the toggle state. In halve mode the x bit that flips the toggle is also the bit being gated, and in scaled add mode an aux 1 arrives while the multiplexer picks its operand. The bench provokes both with dense pseudo-random streams, long runs of ones, and valid gaps placed right after a pending toggle. It judges each output bit against a behavioural model in which the result always uses the state from before the update and the flip appears only on the next accepted bit.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

  typedef enum logic [1:0] {
    OP_MUL   = 2'b00,
    OP_SADD  = 2'b01,
    OP_ADIFF = 2'b10,
    OP_HALF  = 2'b11
  } sc_op_e;

  function automatic logic f_and(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic f_pick(input logic sel, input logic when_one, input logic when_zero);
    return sel ? when_one : when_zero;
  endfunction

  function automatic logic f_xor(input logic a, input logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/sc_delay_elem.sv
module sc_delay_elem #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d_in,
  output logic d_out
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sr <= '0;
        else if (en) sr <= d_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sr <= '0;
        else if (en) sr <= {sr[DEPTH-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = sr[DEPTH-1];
endmodule

// File: rtl/sc_toggle_elem.sv
module sc_toggle_elem (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic t_in,
  output logic t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  t_q <= 1'b0;
    else if (en) t_q <= t_q ^ t_in;
  end
endmodule

// File: rtl/sc_op_core.sv
module sc_op_core
  import sc_alu_pkg::*;
(
  input  sc_op_e op,
  input  logic   x,
  input  logic   y,
  input  logic   aux,
  input  logic   iso,
  input  logic   tog,
  output logic   z,
  output logic   tog_src
);
  always_comb begin
    z       = 1'b0;
    tog_src = 1'b0;
    unique case (op)
      OP_MUL:   z = f_and(x, iso);
      OP_SADD: begin
        z       = f_pick(tog, x, y);
        tog_src = aux;
      end
      OP_ADIFF: z = f_xor(x, y);
      OP_HALF: begin
        z       = f_and(x, tog);
        tog_src = x;
      end
      default:  z = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_stream_alu.sv
module sc_stream_alu
  import sc_alu_pkg::*;
#(
  parameter int ISO_DEPTH = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic       x_bit,
  input  logic       y_bit,
  input  logic       aux_bit,
  input  logic [1:0] op_sel,
  output logic       z_bit,
  output logic       z_vld
);
  sc_op_e op_q;
  logic   iso_q;
  logic   tog_q;
  logic   tog_src;
  logic   z_next;

  // Operation is sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) op_q <= sc_op_e'(op_sel);
  end

  sc_delay_elem #(.DEPTH(ISO_DEPTH)) u_iso (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .d_in(y_bit), .d_out(iso_q)
  );

  sc_toggle_elem u_tog (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .t_in(tog_src), .t_q(tog_q)
  );

  sc_op_core u_core (
    .op(op_q), .x(x_bit), .y(y_bit), .aux(aux_bit),
    .iso(iso_q), .tog(tog_q), .z(z_next), .tog_src(tog_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_bit <= 1'b0;
      z_vld <= 1'b0;
    end else begin
      z_bit <= in_vld & z_next;
      z_vld <= in_vld;
    end
  end
endmodule

// File: rtl/sc_stream_alu_chk.sv
module sc_stream_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_vld,
  input logic       x_bit,
  input logic       y_bit,
  input logic [1:0] op_q,
  input logic       iso_q,
  input logic       tog_q,
  input logic       tog_src,
  input logic       z_bit,
  input logic       z_vld
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> z_vld); // R2
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !z_vld); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !z_vld |-> !z_bit); // R2
  AST_OP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(op_q)); // R3
  AST_MUL_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_q == 2'b00) |=> (z_bit == $past(x_bit & iso_q))); // R4
  AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (tog_q == ($past(tog_q) ^ $past(tog_src)))); // R5
  AST_DIFF_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_q == 2'b10) |=> (z_bit == $past(x_bit ^ y_bit))); // R7
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(tog_q) && $stable(iso_q))); // R9
endmodule

bind sc_stream_alu sc_stream_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_bit(x_bit), .y_bit(y_bit),
  .op_q(op_q), .iso_q(iso_q), .tog_q(tog_q), .tog_src(tog_src),
  .z_bit(z_bit), .z_vld(z_vld)
);

// File: tb/tb_sc_stream_alu.sv
module tb_sc_stream_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic       x_bit = 1'b0, y_bit = 1'b0, aux_bit = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic       z_bit, z_vld;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  int  m_op, m_prev_y, m_tog;
  bit  p_vld, p_z;
  string cur_req = "R4";
  logic [15:0] lfsr = 16'hACE1;
  int  ones_in, ones_out;

  always #4 clk = ~clk;

  sc_stream_alu dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_bit(x_bit), .y_bit(y_bit),
    .aux_bit(aux_bit), .op_sel(op_sel), .z_bit(z_bit), .z_vld(z_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic do_reset(input logic [1:0] op);
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; op_sel = op;
    repeat (4) @(negedge clk);
    check("R1", z_vld, 0);
    check("R1", z_bit, 0);
    rst_n = 1'b1;
    m_op = op; m_prev_y = 0; m_tog = 0;
    p_vld = 0; p_z = 0;
  endtask

  // called at a falling edge: compare the previous bit, then drive a new one
  task automatic step(input bit v, input bit x, input bit y, input bit a);
    int ez, src;
    check("R2", z_vld, p_vld);
    if (p_vld) check(cur_req, z_bit, p_z);
    else       check("R2", z_bit, 0);
    if (z_vld && z_bit) ones_out++;
    in_vld = v; x_bit = x; y_bit = y; aux_bit = a;
    ez = 0; src = 0;
    if (v) begin
      case (m_op)
        0: ez = x & m_prev_y;
        1: begin ez = m_tog ? x : y; src = a; end
        2: ez = x ^ y;
        default: begin ez = x & m_tog; src = x; end
      endcase
      m_prev_y = y;
      m_tog = m_tog ^ src;
      if (x) ones_in++;
    end
    p_vld = v; p_z = ez[0];
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [7:0] xa, ya;
    xa = 8'b11101110; ya = 8'b01110010;

    // R4, R10: multiply, op 00, worked streams then random
    do_reset(2'b00);
    cur_req = "R4";
    for (int i = 7; i >= 0; i--) step(1, xa[i], ya[i], 0);
    for (int i = 0; i < 40; i++) step(1, rnd(), rnd(), 0);
    // R3: op change after reset must be ignored
    op_sel = 2'b11; cur_req = "R3";
    for (int i = 0; i < 40; i++) step(1, rnd(), rnd(), rnd());
    // R9: gaps in multiply mode
    cur_req = "R9";
    for (int i = 0; i < 60; i++) step(rnd(), rnd(), rnd(), 0);
    step(0, 0, 0, 0);

    // R6: scaled add with aux tied high alternates starting with y
    do_reset(2'b01);
    cur_req = "R6";
    for (int i = 0; i < 16; i++) step(1, 1'b1, 1'b0, 1'b1);
    // R5: aux-driven toggle with random streams
    cur_req = "R5";
    for (int i = 0; i < 80; i++) step(1, rnd(), rnd(), rnd());
    cur_req = "R9";
    for (int i = 0; i < 60; i++) step(rnd(), rnd(), rnd(), rnd());
    step(0, 0, 0, 0);

    // R7: absolute difference, including equal (correlated) streams
    do_reset(2'b10);
    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin bit b; b = rnd(); step(1, b, b, 0); end
    for (int i = 0; i < 60; i++) step(1, rnd(), rnd(), 0);
    step(0, 0, 0, 0);

    // R8: halve, dense ones and gaps after pending toggles
    do_reset(2'b11);
    cur_req = "R8";
    ones_in = 0; ones_out = 0;
    for (int i = 0; i < 20; i++) step(1, 1'b1, 0, 0);
    for (int i = 0; i < 100; i++) step(1, rnd(), rnd(), 0);
    cur_req = "R9";
    for (int i = 0; i < 80; i++) begin
      bit xx; xx = rnd();
      step(1, xx, 0, 0);
      if (xx) step(0, rnd(), 0, 0);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R8", ones_out, ones_in / 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule